// File: doc/BRIEF.md
# Zero-Default Word Memory Target for APB

This block is a bus target on an APB-style two-phase bus that holds a 4 KB window of 32-bit words. A requester opens each transfer with a setup cycle, in which the select is high and the enable is low. It completes the transfer in the following access cycle, in which both are high. There are no wait states, so every transfer takes exactly two cycles. Writes are committed at the end of the access cycle. Read data is driven during the access cycle and is zero in every other cycle.

Each word has its own written flag. A word that has not been written since the last reset reads back as zero, whatever the storage array holds. Reset clears every flag, so the whole window reads as zero afterwards. Only address bits 11 down to 2 select a word. The upper bits and the two byte-offset bits are ignored.

The sequencer has three states:
- `ST_IDLE`: no transfer is in flight.
- `ST_WR_ACCESS`: the previous cycle was a write setup.
- `ST_RD_ACCESS`: the previous cycle was a read setup.

A setup cycle (select 1, enable 0) moves the sequencer to `ST_WR_ACCESS` when the write line is 1, or to `ST_RD_ACCESS` when it is 0. This is the transition "setup-write" or "setup-read". Any other cycle moves it back to `ST_IDLE`. This is the transition "release". A write is committed only in `ST_WR_ACCESS` while select and enable are both high.

Top module: `zmem_apb_target`

## Requirements
- R1: While reset is low and in the first cycle after it rises, the sequencer is in `ST_IDLE` and `rsp_rdata` is 0.
- R2: A write stores `req_wdata` at word `req_addr[11:2]`. The commit happens only in an access cycle (select 1, enable 1) that directly follows a write setup cycle (select 1, enable 0, write 1).
- R3: In the access cycle of a read, `rsp_rdata` equals the word last written at `req_addr[11:2]`.
- R4: A word not written since reset reads as 0.
- R5: `rsp_rdata` is 0 in every cycle that is not the access cycle of a read. This includes idle cycles, setup cycles and write access cycles.
- R6: A read whose setup directly follows the access cycle of a write to the same word, with no idle cycle between, returns the newly written data.
- R7: Address bits 31..12 and 1..0 have no effect: addresses that differ only in those bits reach the same word.
- R8: A reset asserted after words were written discards them all, so each of them reads 0 afterwards.
- R9: No write is committed in two cases. One is a write setup that is not followed by an access cycle, because select drops. The other is an access cycle (select 1, enable 1) that has no setup cycle before it. In both cases the addressed word keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_addr | input | 32 | Byte address; bits 11..2 select the word |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer (sampled in setup) |
| req_sel | input | 1 | Target select |
| req_enable | input | 1 | Access-phase marker |
| req_wdata | input | 32 | Write data, taken in the access cycle |
| rsp_rdata | output | 32 | Read data, non-zero only in a read access cycle |

## Verification
The assertions assume that the requester follows the two-phase rule: every access cycle is directly preceded by its setup cycle, and address and direction are held between the two. The two protocol-breaking cases named in R9 are the only exceptions, and the bench drives them on purpose. The random stimulus is built only from complete write, read, write-then-immediate-read and idle sequences, so it stays inside that rule. The directed cases add the aborted setup, the stray access, aliased addresses and a reset in the middle of the run.

// File: rtl/zmem_pkg.sv
package zmem_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WR_ACCESS = 2'd1,
        ST_RD_ACCESS = 2'd2
    } zm_phase_e;

endpackage

// File: rtl/zmem_addr_map.sv
module zmem_addr_map #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 2,
    parameter int IDX_W  = 10
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  word_idx
);

    assign word_idx = addr[OFS_W +: IDX_W];

    logic unused_ofs;
    assign unused_ofs = ^addr[OFS_W-1:0];

    generate
        if (ADDR_W > OFS_W + IDX_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^addr[ADDR_W-1:OFS_W+IDX_W];
        end
    endgenerate

endmodule

// File: rtl/zmem_phase_fsm.sv
module zmem_phase_fsm
    import zmem_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sel,
    input  logic      enable,
    input  logic      write,
    output zm_phase_e phase,
    output logic      wr_commit,
    output logic      rd_capture,
    output logic      rd_drive
);

    zm_phase_e phase_q;
    zm_phase_e phase_d;
    logic      setup_cyc;
    logic      access_cyc;

    assign setup_cyc  = sel && !enable;
    assign access_cyc = sel && enable;

    always_comb begin
        phase_d = ST_IDLE;
        unique case (phase_q)
            ST_IDLE, ST_WR_ACCESS, ST_RD_ACCESS: begin
                if (setup_cyc) begin
                    phase_d = write ? ST_WR_ACCESS : ST_RD_ACCESS;
                end else begin
                    phase_d = ST_IDLE;
                end
            end
            default: phase_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= ST_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    always_comb begin
        wr_commit  = 1'b0;
        rd_capture = setup_cyc && !write;
        rd_drive   = 1'b0;
        unique case (phase_q)
            ST_IDLE:      ;
            ST_WR_ACCESS: wr_commit = access_cyc;
            ST_RD_ACCESS: rd_drive  = access_cyc;
            default:      ;
        endcase
    end

    assign phase = phase_q;

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (phase_q == ST_IDLE));

    // R2
    commit_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(sel && !enable && write));

    // R9
    stray_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && enable && write && !$past(sel && !enable)) |-> !wr_commit);

endmodule

// File: rtl/zmem_word_store.sv
module zmem_word_store #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 1024,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_cap,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_q
);

    logic [DATA_W-1:0] mem [WORDS];
    logic [WORDS-1:0]  written;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            written <= '0;
        end else if (wr_en) begin
            written[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_cap && written[rd_idx]) begin
            rd_q <= mem[rd_idx];
        end else begin
            rd_q <= '0;
        end
    end

    // R8
    flags_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (written == '0));

    // R4
    unwritten_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cap && !written[rd_idx]) |=> (rd_q == '0));

    // R6
    write_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cap && $past(wr_en) && (rd_idx == $past(wr_idx)))
        |=> (rd_q == $past(wr_data, 2)));

endmodule

// File: rtl/zmem_apb_target.sv
module zmem_apb_target
    import zmem_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int DATA_W       = 32,
    parameter int WINDOW_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_sel,
    input  logic              req_enable,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam int BYTE_LANES = DATA_W / 8;
    localparam int OFS_W      = $clog2(BYTE_LANES);
    localparam int WORDS      = WINDOW_BYTES / BYTE_LANES;
    localparam int IDX_W      = $clog2(WORDS);

    logic [IDX_W-1:0]  word_idx;
    zm_phase_e         phase;
    logic              wr_commit;
    logic              rd_capture;
    logic              rd_drive;
    logic [DATA_W-1:0] rd_q;

    zmem_addr_map #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W),
        .IDX_W  (IDX_W)
    ) u_map (
        .addr     (req_addr),
        .word_idx (word_idx)
    );

    zmem_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (req_sel),
        .enable     (req_enable),
        .write      (req_write),
        .phase      (phase),
        .wr_commit  (wr_commit),
        .rd_capture (rd_capture),
        .rd_drive   (rd_drive)
    );

    zmem_word_store #(
        .DATA_W (DATA_W),
        .WORDS  (WORDS),
        .IDX_W  (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_commit),
        .wr_idx  (word_idx),
        .wr_data (req_wdata),
        .rd_cap  (rd_capture),
        .rd_idx  (word_idx),
        .rd_q    (rd_q)
    );

    assign rsp_rdata = rd_drive ? rd_q : '0;

    // R5
    rdata_only_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_rdata != '0) |-> ($past(req_sel && !req_enable && !req_write)
                               && phase == ST_RD_ACCESS));

endmodule

// File: tb/zmem_apb_target_bench.sv
`timescale 1ns/1ps
module zmem_apb_target_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_sel = 1'b0;
    logic        req_enable = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int failures = 0;

    logic [31:0] model [1024];
    logic        mvalid [1024];

    always #2.5 clk = ~clk;

    zmem_apb_target u_zmem_apb_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_addr   (req_addr),
        .req_write  (req_write),
        .req_sel    (req_sel),
        .req_enable (req_enable),
        .req_wdata  (req_wdata),
        .rsp_rdata  (rsp_rdata)
    );

    function automatic logic [31:0] expect_word(input logic [31:0] a);
        int i = int'(a[11:2]);
        return mvalid[i] ? model[i] : 32'd0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < 1024; i++) mvalid[i] = 1'b0;
    endtask

    task automatic bus_idle();
        @(negedge clk);
        req_sel = 1'b0; req_enable = 1'b0; req_wdata = '0;
        #1 chk("R5 idle", rsp_rdata, 32'd0);
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        req_addr = a; req_write = 1'b1; req_sel = 1'b1; req_enable = 1'b0; req_wdata = d;
        #1 chk("R5 write setup", rsp_rdata, 32'd0);
        @(negedge clk);
        req_enable = 1'b1;
        #1 chk("R5 write access", rsp_rdata, 32'd0);
        model[a[11:2]] = d;
        mvalid[a[11:2]] = 1'b1;
    endtask

    task automatic bus_read(input logic [31:0] a, input string req);
        @(negedge clk);
        req_addr = a; req_write = 1'b0; req_sel = 1'b1; req_enable = 1'b0;
        #1 chk("R5 read setup", rsp_rdata, 32'd0);
        @(negedge clk);
        req_enable = 1'b1;
        #1 chk(req, rsp_rdata, expect_word(a));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_sel = 1'b0; req_enable = 1'b0;
        #1 chk("R1 during reset", rsp_rdata, 32'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        clear_model();
        #1 chk("R1 after reset", rsp_rdata, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] a;
        logic [31:0] d;
        void'($urandom(32'd4242));
        clear_model();
        #1 chk("R1 in reset", rsp_rdata, 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R1 first cycle", rsp_rdata, 32'd0);

        // R4 untouched words
        bus_read(32'h0000_0000, "R4 unwritten low");
        bus_read(32'h0000_0FFC, "R4 unwritten high");
        bus_idle();

        // R2 / R3 basic
        bus_write(32'h0000_0010, 32'hDEAD_BEEF);
        bus_idle();
        bus_read(32'h0000_0010, "R3 readback");
        bus_idle();

        // R6 back-to-back write then read
        bus_write(32'h0000_0FFC, 32'h1234_5678);
        bus_read(32'h0000_0FFC, "R6 immediate read");
        bus_write(32'h0000_0FFC, 32'hA5A5_0F0F);
        bus_read(32'h0000_0FFC, "R6 overwrite immediate");
        bus_idle();

        // R7 aliasing through ignored bits
        bus_write(32'hFFFF_F023, 32'hCAFE_0001);
        bus_idle();
        bus_read(32'h0000_0020, "R7 alias clean");
        bus_read(32'h1234_5022, "R7 alias dirty");
        bus_idle();

        // R9 aborted write setup
        @(negedge clk);
        req_addr = 32'h0000_0010; req_write = 1'b1; req_sel = 1'b1; req_enable = 1'b0;
        req_wdata = 32'h0BAD_0BAD;
        bus_idle();
        bus_read(32'h0000_0010, "R9 aborted setup");
        bus_idle();

        // R9 stray access without setup
        @(negedge clk);
        req_addr = 32'h0000_0040; req_write = 1'b1; req_sel = 1'b1; req_enable = 1'b1;
        req_wdata = 32'h7777_7777;
        #1 chk("R5 stray access", rsp_rdata, 32'd0);
        bus_idle();
        bus_read(32'h0000_0040, "R9 stray access");
        bus_idle();

        // random traffic
        for (int n = 0; n < 400; n++) begin
            a = {$urandom} & 32'h0000_00FC;
            if ($urandom_range(0, 3) == 0) a = a | ({$urandom} & 32'hFFFF_F003);
            d = $urandom;
            case ($urandom_range(0, 3))
                0: bus_write(a, d);
                1: bus_read(a, "R3 random read");
                2: begin bus_write(a, d); bus_read(a, "R6 random write-read"); end
                default: bus_idle();
            endcase
        end
        bus_idle();

        // R8 reset discards contents
        bus_write(32'h0000_0100, 32'h5555_AAAA);
        bus_idle();
        do_reset();
        bus_read(32'h0000_0100, "R8 cleared word");
        bus_read(32'h0000_0010, "R8 cleared word 2");
        bus_read(32'h0000_0FFC, "R8 cleared word 3");
        bus_idle();

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule